// File: doc/BRIEF.md
# Ambient-Light Windowed Threshold Interrupt

This block decides when an ambient-light sensor raises its active-low interrupt. Each time a new channel 0 conversion result arrives, it is compared with a programmable 16-bit low limit and high limit. A persistence count sets how many consecutive out-of-window conversions must occur before the interrupt is raised. A persistence of zero raises it after every conversion.

A 2-bit mode selects how the interrupt behaves. It can be off, level style, alert style, or software-forced. Once raised, the interrupt stays pending until a command-byte clear arrives. In the alert modes it can also be cleared by an alert-response read that this device wins on the bus. When the device loses that arbitration, the interrupt stays pending. While an alert is pending, the block supplies the data byte for the alert response, with its own 7-bit address in bits 7:1. A three-level select input picks that address.

The bus engine and the open-drain pad sit outside this block. They present the register fields as levels and present events as one-cycle strobes.

Top module: `alsint_ctrl`

## Requirements
- R1: A conversion result is out of window when it is less than or equal to the low limit, or strictly greater than the high limit. Only out-of-window results advance the persistence run.
- R2: With persistence 0, every conversion raises the interrupt, whatever the limits are.
- R3: With persistence N (1 to 15), the interrupt is raised on the Nth consecutive out-of-window conversion. An in-window conversion restarts the run from zero.
- R4: The run counter saturates at 15. With persistence 15, the interrupt is raised on the 15th out-of-window conversion and stays raised through further ones.
- R5: Mode encodings are 00 off, 01 level, 10 alert and 11 forced. In mode 00, `irq_n` stays high and conversions set nothing pending.
- R6: A `cfg_wr` strobe while the mode is 11 makes `irq_n` low on the next cycle, with no conversion needed.
- R7: A `cmd_clr` strobe clears a pending interrupt, so `irq_n` is high on the next cycle. If an interrupt is raised in the same cycle, the raise wins.
- R8: In modes 10 and 11, a `ara_rd` strobe with `ara_lost` low clears a pending interrupt. In mode 01, `ara_rd` has no effect.
- R9: A `ara_rd` strobe with `ara_lost` high leaves the interrupt pending.
- R10: `ara_ack` is high exactly when the mode is 10 or 11 and an interrupt is pending. `ara_byte` carries the own address in bits 7:1 and 0 in bit 0. The address is 0101001 for `addr_sel` 00, 0111001 for 01 or 11, and 1001001 for 10.
- R11: After reset, nothing is pending: `irq_n` is high and `ara_ack` is low.
- R12: Any clear, and any `cfg_wr` strobe, restarts the persistence run from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_vld | input | 1 | One-cycle strobe: a new channel 0 result is present |
| res_val | input | 16 | Channel 0 conversion result |
| lim_lo | input | 16 | Low limit (inclusive) |
| lim_hi | input | 16 | High limit (exclusive) |
| irq_mode | input | 2 | Interrupt mode field |
| persist | input | 4 | Persistence field |
| cfg_wr | input | 1 | Strobe: the interrupt control field was written |
| cmd_clr | input | 1 | Strobe: command byte with the clear bit set |
| ara_rd | input | 1 | Strobe: alert-response read completed |
| ara_lost | input | 1 | Arbitration lost during that alert-response read |
| addr_sel | input | 2 | Address select: 00 low, 01 floating, 10 high |
| irq_n | output | 1 | Active-low interrupt |
| ara_ack | output | 1 | Device answers an alert-response read |
| ara_byte | output | 8 | Alert-response data byte |

## Verification
The bench sweeps results across both window edges, one below, on and above each limit. A design that used a strict compare at the low edge, or an inclusive compare at the high edge, fails these checks. It runs persistence values 0 through 4 and 15 with an exact count of out-of-window results. A counter that is off by one, or that does not saturate, raises the interrupt one conversion early or late. It also inserts an in-window result mid-run; a design that does not restart the run would then raise the interrupt too soon. The alert path is exercised with both won and lost arbitration, and also in level mode. A design that gated clearing on the wrong mode, or ignored the arbitration outcome, would drop or keep the interrupt wrongly.

// File: rtl/alsint_pkg.sv
package alsint_pkg;
    localparam int RES_W  = 16;
    localparam int PER_W  = 4;
    localparam int ADDR_W = 7;

    typedef enum logic [1:0] {
        IRQ_OFF   = 2'b00,
        IRQ_LEVEL = 2'b01,
        IRQ_ALERT = 2'b10,
        IRQ_FORCE = 2'b11
    } irq_mode_e;

    function automatic logic [ADDR_W-1:0] own_addr(input logic [1:0] sel);
        case (sel)
            2'b00:   own_addr = 7'b0101001;
            2'b10:   own_addr = 7'b1001001;
            default: own_addr = 7'b0111001;
        endcase
    endfunction
endpackage

// File: rtl/alsint_window.sv
module alsint_window #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic         outside
);
    logic below_q, above_q;
    always_comb begin
        below_q = (val <= lo);
        above_q = (val > hi);
        outside = below_q | above_q;
    end
endmodule

// File: rtl/alsint_persist.sv
module alsint_persist #(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample,
    input  logic          outside,
    input  logic [PW-1:0] limit,
    input  logic          restart,
    output logic          fire
);
    localparam logic [PW-1:0] CNT_MAX = {PW{1'b1}};

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pst_t;

    pst_t st_d, st_q;
    logic [PW-1:0] inc;

    always_comb begin
        st_d = st_q;
        inc  = (st_q.cnt == CNT_MAX) ? CNT_MAX : st_q.cnt + 1'b1;
        fire = sample && ((limit == '0) || (outside && (inc >= limit)));
        if (restart)
            st_d.cnt = '0;
        else if (sample)
            st_d.cnt = outside ? inc : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    run_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !outside) |=> (st_q.cnt == '0));

    // R4
    run_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_MAX && sample && outside && !restart) |=> (st_q.cnt == CNT_MAX));

    // R12
    run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.cnt == '0));
endmodule

// File: rtl/alsint_ctrl.sv
module alsint_ctrl
    import alsint_pkg::*;
#(
    parameter int RW = RES_W,
    parameter int PW = PER_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          res_vld,
    input  logic [RW-1:0] res_val,
    input  logic [RW-1:0] lim_lo,
    input  logic [RW-1:0] lim_hi,
    input  logic [1:0]    irq_mode,
    input  logic [PW-1:0] persist,
    input  logic          cfg_wr,
    input  logic          cmd_clr,
    input  logic          ara_rd,
    input  logic          ara_lost,
    input  logic [1:0]    addr_sel,
    output logic          irq_n,
    output logic          ara_ack,
    output logic [7:0]    ara_byte
);
    typedef struct packed {
        logic pend;
    } ctl_t;

    ctl_t      st_d, st_q;
    irq_mode_e mode;
    logic      outside, fire, raise, drop, ara_win, restart;

    alsint_window #(.W(RW)) u_win (
        .val(res_val), .lo(lim_lo), .hi(lim_hi), .outside(outside)
    );

    alsint_persist #(.PW(PW)) u_pst (
        .clk(clk), .rst_n(rst_n), .sample(res_vld), .outside(outside),
        .limit(persist), .restart(restart), .fire(fire)
    );

    always_comb begin
        mode     = irq_mode_e'(irq_mode);
        st_d     = st_q;
        ara_win  = ara_rd && mode[1] && st_q.pend && !ara_lost;
        raise    = (fire && mode != IRQ_OFF) || (cfg_wr && mode == IRQ_FORCE);
        drop     = cmd_clr || ara_win;
        restart  = drop || cfg_wr;
        if (raise)     st_d.pend = 1'b1;
        else if (drop) st_d.pend = 1'b0;
        irq_n    = !(st_q.pend && mode != IRQ_OFF);
        ara_ack  = st_q.pend && mode[1];
        ara_byte = {own_addr(addr_sel), 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6
    force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && irq_mode == 2'b11) |=> !irq_n);

    // R9
    arb_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ara_rd && ara_lost && !cmd_clr && st_q.pend) |=> st_q.pend);

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_clr && !res_vld && !cfg_wr) |=> irq_n);

    // R5
    off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mode == 2'b00) |-> irq_n);

    // R10
    ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ara_ack |-> (!irq_n && irq_mode[1]));
endmodule

// File: tb/tb_alsint_ctrl.sv
module tb_alsint_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_vld = 1'b0;
    logic [15:0] res_val = '0;
    logic [15:0] lim_lo = 16'd100;
    logic [15:0] lim_hi = 16'd200;
    logic [1:0]  irq_mode = 2'b01;
    logic [3:0]  persist = 4'd1;
    logic        cfg_wr = 1'b0, cmd_clr = 1'b0, ara_rd = 1'b0, ara_lost = 1'b0;
    logic [1:0]  addr_sel = 2'b00;
    logic        irq_n, ara_ack;
    logic [7:0]  ara_byte;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    alsint_ctrl dut (.*);

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic conv(input logic [15:0] v);
        @(negedge clk); res_val = v; res_vld = 1'b1;
        @(negedge clk); res_vld = 1'b0;
    endtask

    task automatic clr();
        @(negedge clk); cmd_clr = 1'b1;
        @(negedge clk); cmd_clr = 1'b0;
    endtask

    task automatic cfg(input logic [1:0] m, input logic [3:0] p);
        @(negedge clk); irq_mode = m; persist = p; cfg_wr = 1'b1;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic ara(input logic lost);
        @(negedge clk); ara_rd = 1'b1; ara_lost = lost;
        @(negedge clk); ara_rd = 1'b0; ara_lost = 1'b0;
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] vals [6];
        vals = '{16'd99, 16'd100, 16'd101, 16'd199, 16'd200, 16'd201};
        repeat (2) @(negedge clk);
        // R11
        chk("R11 irq_n", irq_n, 1);
        chk("R11 ack", ara_ack, 0);
        rst_n = 1'b1;

        // R1: boundary sweep, persistence 1
        cfg(2'b01, 4'd1);
        for (int i = 0; i < 6; i++) begin
            conv(vals[i]);
            chk("R1 window", irq_n, (vals[i] <= 100 || vals[i] > 200) ? 0 : 1);
            clr();
            // R7
            chk("R7 clear", irq_n, 1);
        end

        // R2 / R3: persistence sweep with out-of-window results
        for (int p = 0; p <= 4; p++) begin
            cfg(2'b01, p[3:0]);
            clr();
            for (int k = 1; k <= 5; k++) begin
                conv(p == 0 ? 16'd150 : 16'd50);
                chk(p == 0 ? "R2 every" : "R3 persist", irq_n, (k >= (p == 0 ? 1 : p)) ? 0 : 1);
            end
        end

        // R3: in-window result restarts the run
        cfg(2'b01, 4'd3); clr();
        conv(16'd50); conv(16'd50); conv(16'd150);
        conv(16'd50); conv(16'd50);
        chk("R3 restart", irq_n, 1);
        conv(16'd50);
        chk("R3 third", irq_n, 0);

        // R12: clear restarts the run
        cfg(2'b01, 4'd2); clr();
        conv(16'd50); clr(); conv(16'd50);
        chk("R12 clr restart", irq_n, 1);
        conv(16'd50);
        chk("R12 after", irq_n, 0);

        // R4: saturation at 15
        cfg(2'b01, 4'd15); clr();
        for (int k = 1; k <= 20; k++) begin
            conv(16'd300);
            chk("R4 sat", irq_n, (k >= 15) ? 0 : 1);
        end

        // R7: raise wins over clear in the same cycle
        cfg(2'b01, 4'd1); clr();
        @(negedge clk); res_val = 16'd10; res_vld = 1'b1; cmd_clr = 1'b1;
        @(negedge clk); res_vld = 1'b0; cmd_clr = 1'b0;
        chk("R7 raise wins", irq_n, 0);

        // R5: mode off
        cfg(2'b00, 4'd1); clr();
        conv(16'd10);
        chk("R5 off", irq_n, 1);
        @(negedge clk); irq_mode = 2'b01;
        chk("R5 nothing pending", irq_n, 1);

        // R6: forced
        clr();
        cfg(2'b11, 4'd5);
        chk("R6 force", irq_n, 0);
        chk("R10 ack force", ara_ack, 1);
        ara(1'b0);
        chk("R8 force clear", irq_n, 1);

        // R8 / R9 / R10: alert mode with each address select
        for (int s = 0; s < 4; s++) begin
            int exp_a;
            exp_a = (s == 0) ? 8'h52 : (s == 2) ? 8'h92 : 8'h72;
            cfg(2'b10, 4'd1); clr();
            @(negedge clk); addr_sel = s[1:0];
            chk("R10 ack idle", ara_ack, 0);
            conv(16'd500);
            chk("R10 ack", ara_ack, 1);
            chk("R10 byte", ara_byte, exp_a);
            ara(1'b1);
            chk("R9 lost", irq_n, 0);
            ara(1'b0);
            chk("R8 won", irq_n, 1);
        end

        // R8: level mode ignores alert read
        cfg(2'b01, 4'd1); clr();
        conv(16'd500);
        chk("R10 level ack", ara_ack, 0);
        ara(1'b0);
        chk("R8 level ignore", irq_n, 0);
        clr();
        chk("R7 final clr", irq_n, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule